// File: doc/BRIEF.md
# Bit Scan and Population Count Unit

This unit takes a 16-bit source word and an operation code. It computes one of three results: the index of the least significant set bit, the index of the most significant set bit, or the number of set bits. With each result it returns a destination write enable and a six-bit arithmetic flag vector.

The execution stage of a processor datapath uses it for bit-manipulation instructions. Decode and register-file access sit outside the unit. The source is written when `in_valid` and `in_ready` are both high at a rising clock edge. One result comes back for each accepted operation, marked by a one-cycle `done` pulse, and the result outputs keep their values until the next `done`.

Two internal engines are available, chosen by a parameter:
- The parallel engine (default) accepts a new operation on every cycle.
- The serial engine examines one bit per cycle. It applies back-pressure by holding `in_ready` low until its result is out.

The output side has no ready signal. A consumer must capture the result while `done` is high, or at any later time before the next `done`.

Top module: `bitscan_unit`

## Requirements
- R1: Operation code 2'b00 (forward scan) with a non-zero source writes the index of the lowest set bit, from 0 to 15, to `res_data` and raises `res_wr`.
- R2: Operation code 2'b01 (reverse scan) with a non-zero source writes the index of the highest set bit, from 0 to 15, to `res_data` and raises `res_wr`.
- R3: Either scan with a zero source leaves `res_wr` low and `res_data` at zero. The only flag set is zero (bit 3 of `res_flags`).
- R4: The flag vector uses these bit positions: 0 carry, 1 parity, 2 auxiliary carry, 3 zero, 4 sign, 5 overflow. After a scan of a non-zero source, carry, auxiliary carry, overflow and zero are all 0. Sign equals bit 15 of the result. Parity is 1 when the low eight bits of the result hold an even number of ones.
- R5: Operation code 2'b10 (population count) always raises `res_wr` and writes the number of set bits in the source, from 0 to 16. A zero source therefore writes 0.
- R6: After a population count, every flag is 0 except zero (bit 3), which is 1 exactly when the count is 0.
- R7: Operation code 2'b11 raises `res_illegal`. It leaves `res_wr` low and drives `res_data` and `res_flags` to zero.
- R8: In the default parallel configuration `in_ready` stays high, and `done` is high in the cycle right after each accepted operation, once per operation and in order. In the serial configuration `in_ready` is low while an operation is in progress, and `done` follows acceptance after 16 cycles.
- R9: While `done` is low, `res_data`, `res_wr`, `res_flags` and `res_illegal` do not change, whatever happens on `in_op` and `in_src`.
- R10: After reset, `done`, `res_wr`, `res_illegal`, `res_data` and `res_flags` are all zero, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 2 | Operation code: 00 forward scan, 01 reverse scan, 10 count, 11 illegal |
| in_src | input | 16 | Source operand |
| done | output | 1 | One-cycle pulse: a new result is on the outputs |
| res_data | output | 16 | Result word for the destination |
| res_wr | output | 1 | Destination should be written with `res_data` |
| res_flags | output | 6 | Flags: 0 carry, 1 parity, 2 aux carry, 3 zero, 4 sign, 5 overflow |
| res_illegal | output | 1 | The operation code was not a defined operation |

## Verification
The assertions assume the following about the unit's inputs:
- Reset is applied before the first operation.
- `in_op` and `in_src` carry known values whenever `in_valid` is high.
- A requester that sees `in_ready` low keeps its request in place until it is accepted.

The stimulus changes inputs only on the falling clock edge. It holds each request until `in_ready` is seen high, and it sweeps every 16-bit source value through each of the three defined operations. It also drives the undefined code, and it changes the inputs while `in_valid` is low to show that idle cycles leave the outputs unchanged.

// File: rtl/bitscan_pkg.sv
package bitscan_pkg;

  typedef enum logic [1:0] {
    OP_FWD = 2'b00,
    OP_REV = 2'b01,
    OP_CNT = 2'b10,
    OP_BAD = 2'b11
  } bs_op_e;

  localparam int FLAG_N = 6;
  localparam int FL_CF  = 0;
  localparam int FL_PF  = 1;
  localparam int FL_AF  = 2;
  localparam int FL_ZF  = 3;
  localparam int FL_SF  = 4;
  localparam int FL_OF  = 5;

endpackage

// File: rtl/bitscan_prio.sv
module bitscan_prio #(
  parameter int W = 16,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  src,
  input  logic          rev,
  output logic          hit,
  output logic [IW-1:0] pos
);

  assign hit = |src;

  // The last assignment in each loop is the one that wins: walking upward
  // keeps the highest index, walking downward keeps the lowest.
  always_comb begin
    pos = '0;
    if (rev) begin
      for (int i = 0; i < W; i++)
        if (src[i]) pos = IW'(i);
    end else begin
      for (int i = W - 1; i >= 0; i--)
        if (src[i]) pos = IW'(i);
    end
  end

endmodule

// File: rtl/bitscan_popcnt.sv
module bitscan_popcnt #(
  parameter int W = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  src,
  output logic [CW-1:0] cnt
);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++)
      cnt = cnt + CW'(src[i]);
  end

endmodule

// File: rtl/bitscan_iter.sv
module bitscan_iter
  import bitscan_pkg::*;
#(
  parameter int W = 16,
  localparam int IW = $clog2(W),
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  bs_op_e        op,
  input  logic [W-1:0]  src,
  output logic          busy,
  output logic          last,
  output bs_op_e        op_out,
  output logic          found,
  output logic [CW-1:0] value
);

  logic          busy_q;
  logic [IW-1:0] idx_q;
  logic [W-1:0]  src_q;
  bs_op_e        op_q;
  logic          found_q;
  logic [IW-1:0] pos_q;
  logic [CW-1:0] cnt_q;

  logic          bit_now;
  logic [IW-1:0] pos_n;
  logic [CW-1:0] cnt_n;

  assign bit_now = src_q[idx_q];
  assign cnt_n   = cnt_q + CW'(bit_now);
  assign found   = found_q | bit_now;
  assign last    = busy_q && (idx_q == IW'(W - 1));
  assign busy    = busy_q;
  assign op_out  = op_q;

  // Reverse scan keeps overwriting with later hits; forward keeps the first.
  always_comb begin
    pos_n = pos_q;
    if (bit_now && (op_q == OP_REV || !found_q))
      pos_n = idx_q;
  end

  assign value = (op_q == OP_CNT) ? cnt_n : CW'(pos_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      src_q   <= '0;
      op_q    <= OP_FWD;
      found_q <= 1'b0;
      pos_q   <= '0;
      cnt_q   <= '0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      idx_q   <= '0;
      src_q   <= src;
      op_q    <= op;
      found_q <= 1'b0;
      pos_q   <= '0;
      cnt_q   <= '0;
    end else if (busy_q) begin
      found_q <= found;
      pos_q   <= pos_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_q + 1'b1;
      if (last) busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/bitscan_flags.sv
module bitscan_flags
  import bitscan_pkg::*;
#(
  parameter int W = 16,
  localparam int CW = $clog2(W + 1),
  localparam int PB = (W < 8) ? W : 8
) (
  input  bs_op_e             op,
  input  logic               found,
  input  logic [CW-1:0]      value,
  output logic [W-1:0]       data,
  output logic               wr,
  output logic [FLAG_N-1:0]  flags,
  output logic               illegal
);

  always_comb begin
    data    = '0;
    wr      = 1'b0;
    flags   = '0;
    illegal = 1'b0;
    case (op)
      OP_FWD, OP_REV: begin
        if (found) begin
          data         = W'(value);
          wr           = 1'b1;
          flags[FL_PF] = ~^data[PB-1:0];
          flags[FL_SF] = data[W-1];
        end else begin
          flags[FL_ZF] = 1'b1;
        end
      end
      OP_CNT: begin
        data         = W'(value);
        wr           = 1'b1;
        flags[FL_ZF] = (value == '0);
      end
      default: illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/bitscan_unit.sv
module bitscan_unit
  import bitscan_pkg::*;
#(
  parameter int W         = 16,
  parameter bit ITERATIVE = 1'b0,
  localparam int IW = $clog2(W),
  localparam int CW = $clog2(W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [W-1:0]      in_src,
  output logic              done,
  output logic [W-1:0]      res_data,
  output logic              res_wr,
  output logic [FLAG_N-1:0] res_flags,
  output logic              res_illegal
);

  bs_op_e        op_in;
  logic          load;
  bs_op_e        raw_op;
  logic          raw_found;
  logic [CW-1:0] raw_value;

  assign op_in = bs_op_e'(in_op);

  generate
    if (ITERATIVE) begin : g_serial
      logic busy;

      bitscan_iter #(.W(W)) u_iter (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (in_valid && !busy),
        .op     (op_in),
        .src    (in_src),
        .busy   (busy),
        .last   (load),
        .op_out (raw_op),
        .found  (raw_found),
        .value  (raw_value)
      );

      assign in_ready = !busy;

      AST_SERIAL_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> in_ready); // R8
    end else begin : g_parallel
      logic          sc_hit;
      logic [IW-1:0] sc_pos;
      logic [CW-1:0] pc_cnt;
      logic          acc;

      bitscan_prio #(.W(W)) u_prio (
        .src (in_src),
        .rev (op_in == OP_REV),
        .hit (sc_hit),
        .pos (sc_pos)
      );

      bitscan_popcnt #(.W(W)) u_popcnt (
        .src (in_src),
        .cnt (pc_cnt)
      );

      assign in_ready  = 1'b1;
      assign acc       = in_valid && in_ready;
      assign load      = acc;
      assign raw_op    = op_in;
      assign raw_found = sc_hit;
      assign raw_value = (op_in == OP_CNT) ? pc_cnt : CW'(sc_pos);

      AST_DONE_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> done); // R8
      AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(acc)); // R8
    end
  endgenerate

  logic [W-1:0]      f_data;
  logic              f_wr;
  logic [FLAG_N-1:0] f_flags;
  logic              f_ill;

  bitscan_flags #(.W(W)) u_flags (
    .op      (raw_op),
    .found   (raw_found),
    .value   (raw_value),
    .data    (f_data),
    .wr      (f_wr),
    .flags   (f_flags),
    .illegal (f_ill)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      res_data    <= '0;
      res_wr      <= 1'b0;
      res_flags   <= '0;
      res_illegal <= 1'b0;
    end else begin
      done <= load;
      if (load) begin
        res_data    <= f_data;
        res_wr      <= f_wr;
        res_flags   <= f_flags;
        res_illegal <= f_ill;
      end
    end
  end

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_illegal) |-> !res_wr); // R7
  AST_SKIP_ONLY_ZF: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_wr && !res_illegal) |-> (res_flags == FLAG_N'(1 << FL_ZF))); // R3
  AST_NONZERO_CLEARS_ZF: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_wr && res_data != '0) |-> !res_flags[FL_ZF]); // R4
  AST_FIXED_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!res_flags[FL_CF] && !res_flags[FL_AF] && !res_flags[FL_OF] && !res_flags[FL_SF])); // R4
  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_wr) |-> (res_data <= W'(W))); // R5
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_data) && $stable(res_wr) && $stable(res_flags) && $stable(res_illegal))); // R9

endmodule

// File: tb/test_bitscan_unit.sv
`timescale 1ns/1ps
module test_bitscan_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  in_op;
  logic [15:0] in_src;
  logic        done;
  logic [15:0] res_data;
  logic        res_wr;
  logic [5:0]  res_flags;
  logic        res_illegal;

  always #5 clk = ~clk;

  bitscan_unit i_bitscan_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_op       (in_op),
    .in_src      (in_src),
    .done        (done),
    .res_data    (res_data),
    .res_wr      (res_wr),
    .res_flags   (res_flags),
    .res_illegal (res_illegal)
  );

  typedef struct {
    logic [15:0] data;
    logic        wr;
    logic [5:0]  flags;
    logic        ill;
    logic [1:0]  op;
    logic [15:0] src;
  } exp_t;

  exp_t sb[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  int   n_sent  = 0;
  int   n_done  = 0;

  function automatic exp_t model(logic [1:0] op, logic [15:0] src);
    exp_t e;
    int   lo;
    int   hi;
    int   n;
    int   p;
    lo = -1; hi = -1; n = 0;
    for (int i = 0; i < 16; i++)
      if (src[i]) begin
        if (lo < 0) lo = i;
        hi = i;
        n++;
      end
    e.data = '0; e.wr = 1'b0; e.flags = '0; e.ill = 1'b0;
    e.op = op; e.src = src;
    case (op)
      2'b00, 2'b01: begin
        if (src == 16'h0) e.flags[3] = 1'b1;
        else begin
          e.wr   = 1'b1;
          e.data = (op == 2'b00) ? 16'(lo) : 16'(hi);
          p = 0;
          for (int j = 0; j < 8; j++) p += int'(e.data[j]);
          e.flags[1] = (p % 2 == 0);
          e.flags[4] = e.data[15];
        end
      end
      2'b10: begin
        e.wr       = 1'b1;
        e.data     = 16'(n);
        e.flags[3] = (n == 0);
      end
      default: e.ill = 1'b1;
    endcase
    return e;
  endfunction

  function automatic string tag_data(logic [1:0] op, logic [15:0] src);
    case (op)
      2'b00:   return (src == 0) ? "R3" : "R1";
      2'b01:   return (src == 0) ? "R3" : "R2";
      2'b10:   return "R5";
      default: return "R7";
    endcase
  endfunction

  function automatic string tag_flags(logic [1:0] op, logic [15:0] src);
    case (op)
      2'b00, 2'b01: return (src == 0) ? "R3" : "R4";
      2'b10:        return "R6";
      default:      return "R7";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // Driver: present a request, wait for acceptance, record the expectation.
  task automatic send(logic [1:0] op, logic [15:0] src);
    in_valid = 1'b1;
    in_op    = op;
    in_src   = src;
    while (!in_ready) @(negedge clk);
    sb.push_back(model(op, src));
    n_sent++;
    @(negedge clk);
  endtask

  // Monitor: every result pulse is matched against the oldest expectation.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        n_done++;
        if (sb.size() == 0) begin
          check(1'b0, "R8", "done without pending request", 32'd1, 32'd0);
        end else begin
          e = sb.pop_front();
          check(res_data == e.data && res_wr == e.wr && res_illegal == e.ill,
                tag_data(e.op, e.src), $sformatf("op %0d src %04h {ill,wr,data}", e.op, e.src),
                {14'd0, res_illegal, res_wr, res_data}, {14'd0, e.ill, e.wr, e.data});
          check(res_flags == e.flags, tag_flags(e.op, e.src),
                $sformatf("op %0d src %04h flags", e.op, e.src),
                {26'd0, res_flags}, {26'd0, e.flags});
        end
      end
    end
  end

  initial begin
    repeat (199000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] snap_data;
    logic [5:0]  snap_flags;
    logic        snap_wr;
    logic        snap_ill;

    in_valid = 1'b0;
    in_op    = 2'b00;
    in_src   = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: state straight after reset
    check(done == 1'b0 && res_wr == 1'b0 && res_illegal == 1'b0, "R10", "done/wr/illegal after reset",
          {29'd0, done, res_wr, res_illegal}, 32'd0);
    check(res_data == 16'h0 && res_flags == 6'h0, "R10", "data/flags after reset",
          {10'd0, res_flags, res_data}, 32'd0);
    check(in_ready == 1'b1, "R10", "in_ready after reset", {31'd0, in_ready}, 32'd1);

    // R1 R2 R3 R4 R5 R6: every source value for each defined operation, back to back
    for (int op = 0; op < 3; op++)
      for (int v = 0; v < 65536; v++)
        send(2'(op), 16'(v));

    // R7: undefined operation code
    send(2'b11, 16'h0000);
    send(2'b11, 16'hFFFF);
    send(2'b11, 16'h8001);
    send(2'b11, 16'h0100);
    in_valid = 1'b0;

    // R8: the last accepted request produces its pulse in the next cycle
    check(done == 1'b1 && res_illegal == 1'b1, "R8", "done after last accept",
          {30'd0, done, res_illegal}, 32'd3);
    snap_data  = res_data;
    snap_flags = res_flags;
    snap_wr    = res_wr;
    snap_ill   = res_illegal;

    // R9: idle cycles with moving inputs leave every result output untouched
    for (int k = 0; k < 8; k++) begin
      in_op  = 2'(k);
      in_src = 16'h1 << k;
      @(negedge clk);
      check(done == 1'b0, "R9", "done while idle", {31'd0, done}, 32'd0);
      check(res_data == snap_data && res_flags == snap_flags && res_wr == snap_wr && res_illegal == snap_ill,
            "R9", "held outputs while idle",
            {8'd0, res_illegal, res_wr, res_flags, res_data},
            {8'd0, snap_ill, snap_wr, snap_flags, snap_data});
    end

    // R8: one pulse per request, none left outstanding
    check(n_done == n_sent && sb.size() == 0, "R8", "pulse count vs requests",
          32'(n_done), 32'(n_sent));

    summary();
    $finish;
  end

endmodule